// File: doc/BRIEF.md
# HS Burst Entry/Exit Sequencer for a Clock Lane and a Data Lane

This block sequences one clock lane and one data lane of a serial camera-style transmitter through the move from low-power signalling to high-speed bursts and back. It runs from one timing clock whose period (`CLK_PS`) is known at build time, together with the unit-interval period (`UI_PS`) of the high-speed link. Each timing rule has a fixed nanosecond term plus a term scaled by the UI. The block turns every such rule into a whole number of timing-clock cycles with ceil((ns + k·UI) / clock period). Where a rule gives a window, the count uses the window's midpoint.

The clock lane leaves low power first and runs a few UI of clock. Then the data lane enters high speed, sends its zero run and then a one-cycle sync strobe, and passes payload bytes from a packet layer through a valid/ready handshake. After the last byte, the data lane sends its trail and drops back to LP-11. The clock keeps running for its post interval, then sends its own trail, and both lanes rest in LP-11 before the next request. After power-up the block waits out an init interval. It can also park both lanes in an ultra-low-power state, with a timed wake-up on exit. Analog drivers and serialization are outside this block. The block presents one byte per cycle on `dat_byte`, which a serializer sends LSB first.

Top module: `hs_lane_seq`

## Requirements
- R1: While reset is low and after it, both lanes drive LP-11 (`clk_lp`=`dat_lp`=2'b11) with every HS output low. `lane_idle` rises exactly ceil(INIT_NS·1000/CLK_PS) cycles after reset is released.
- R2: On an accepted request, the clock lane drives LP-01 for ceil(50 ns/T) cycles. It then drives LP-00 for ceil(66.5 ns/T) cycles, which must fall within 38–95 ns. It then drives HS-0 (`clk_hs_en`=1, `clk_hs_zero`=1) so that prepare plus zero lasts at least 300 ns.
- R3: The clock toggles (`clk_hs_en`=1, `clk_hs_zero`=0) for at least 8 UI before the data lane leaves LP-11.
- R4: The data lane drives LP-01 for ceil(50 ns/T) cycles. It then drives LP-00 for the cycle count of the midpoint of 40 ns+4 UI and 85 ns+6 UI, which must lie inside that window. It then drives HS-0 so that prepare plus zero lasts at least 145 ns+10 UI. HS is entered only from LP-00.
- R5: After the zero run, `dat_sync` is high for exactly one cycle with `dat_byte`=8'hB8, and `pay_ready` rises only in the cycle after it.
- R6: `pay_ready` stays high for as long as the payload state lasts. A byte moves on each cycle with `pay_valid` and `pay_ready` both high, and the byte with `pay_last` ends the payload. Cycles with `pay_valid` low lengthen the payload state by the same number of cycles.
- R7: The data trail (`dat_trail`=1) presents `dat_byte` with every bit equal to the inverse of bit 7 of the last payload byte. It lasts at least 60 ns+4 UI and no more than 105 ns+12 UI.
- R8: After the data lane leaves HS it drives LP-11, while the clock keeps toggling for at least 60 ns+52 UI. The data lane is never in HS without a toggling clock.
- R9: The clock trail (`clk_hs_en`=1, `clk_hs_zero`=1 after toggling) lasts at least 60 ns.
- R10: After both trails, both lanes hold LP-11 for at least 100 ns before `lane_idle` rises.
- R11: `burst_req` is accepted only when `lane_idle` is high. A request held or pulsed during a burst or during ULPS starts no burst.
- R12: `ulps_req` in idle drives both lanes to LP-00. When `ulps_req` falls, both lanes drive LP-10 for ceil(WAKE_NS·1000/CLK_PS) cycles and then return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | timing clock |
| rst_n | input | 1 | asynchronous active-low reset |
| burst_req | input | 1 | level request for one HS burst |
| ulps_req | input | 1 | level request to stay in ultra-low-power state |
| pay_valid | input | 1 | packet layer offers a byte |
| pay_last | input | 1 | offered byte is the final one |
| pay_data | input | 8 | payload byte |
| pay_ready | output | 1 | sequencer takes a byte this cycle |
| lane_idle | output | 1 | both lanes idle in LP-11, request may be taken |
| clk_lp | output | 2 | clock lane LP state {P,N} |
| clk_hs_en | output | 1 | clock lane HS driver on |
| clk_hs_zero | output | 1 | clock lane holds HS-0 instead of toggling |
| dat_lp | output | 2 | data lane LP state {P,N} |
| dat_hs_en | output | 1 | data lane HS driver on |
| dat_hs_zero | output | 1 | data lane sends HS-0 |
| dat_sync | output | 1 | sync byte strobe |
| dat_trail | output | 1 | data trail in progress |
| dat_byte | output | 8 | byte for the serializer, LSB first |

## Verification
The bench builds the block with CLK_PS=5000 and UI_PS=1250, which gives 200 cycles per microsecond and an 800 Mbps link. With these values every window has a count of several cycles, so an off-by-one in any interval changes a measured length. INIT_NS=2000 and WAKE_NS=1500 shrink the power-up and wake intervals to 400 and 300 cycles. The init and wake paths can then be timed exactly within the run, while the counter structure still follows the same formula as for 100 µs and 1 ms.

// File: rtl/hs_lane_seq.sv
module hs_lane_seq #(
  parameter int CLK_PS  = 5000,
  parameter int UI_PS   = 1250,
  parameter int INIT_NS = 100000,
  parameter int WAKE_NS = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       burst_req,
  input  logic       ulps_req,
  input  logic       pay_valid,
  input  logic       pay_last,
  input  logic [7:0] pay_data,
  output logic       pay_ready,
  output logic       lane_idle,
  output logic [1:0] clk_lp,
  output logic       clk_hs_en,
  output logic       clk_hs_zero,
  output logic [1:0] dat_lp,
  output logic       dat_hs_en,
  output logic       dat_hs_zero,
  output logic       dat_sync,
  output logic       dat_trail,
  output logic [7:0] dat_byte
);

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int at_least1(input int a);
    return (a < 1) ? 1 : a;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int T_LPX    = at_least1(cdiv(50000, CLK_PS));
  localparam int T_CPREP  = at_least1(cdiv((38000 + 95000) / 2, CLK_PS));
  localparam int T_CZERO  = at_least1(cdiv(300000, CLK_PS) - T_CPREP);
  localparam int T_CPRE   = at_least1(cdiv(8 * UI_PS, CLK_PS));
  localparam int T_DPREP  = at_least1(cdiv((40000 + 4 * UI_PS + 85000 + 6 * UI_PS) / 2, CLK_PS));
  localparam int T_DZERO  = at_least1(cdiv(145000 + 10 * UI_PS, CLK_PS) - T_DPREP);
  localparam int T_DTRAIL = at_least1(cdiv(60000 + 4 * UI_PS, CLK_PS));
  localparam int T_CPOST  = at_least1(cdiv(60000 + 52 * UI_PS, CLK_PS));
  localparam int T_CTRAIL = at_least1(cdiv(60000, CLK_PS));
  localparam int T_EXIT   = at_least1(cdiv(100000, CLK_PS));
  localparam int T_INIT   = at_least1(cdiv(INIT_NS * 1000, CLK_PS));
  localparam int T_WAKE   = at_least1(cdiv(WAKE_NS * 1000, CLK_PS));
  localparam int T_MAX    = max2(max2(T_INIT, T_WAKE), max2(T_CZERO, T_CPOST));
  localparam int CW       = $clog2(T_MAX + 1);

  typedef enum logic [4:0] {
    ST_INIT, ST_IDLE, ST_CLPX, ST_CPREP, ST_CZERO, ST_CPRE,
    ST_DLPX, ST_DPREP, ST_DZERO, ST_DSYNC, ST_DPAY, ST_DTRAIL,
    ST_CPOST, ST_CTRAIL, ST_EXIT, ST_ULPS, ST_WAKE
  } seq_t;

  seq_t          st, nxt;
  logic [CW-1:0] cnt;
  logic          trail_bit;

  function automatic logic [CW-1:0] span(input seq_t s);
    case (s)
      ST_CLPX, ST_DLPX: return CW'(T_LPX - 1);
      ST_CPREP:         return CW'(T_CPREP - 1);
      ST_CZERO:         return CW'(T_CZERO - 1);
      ST_CPRE:          return CW'(T_CPRE - 1);
      ST_DPREP:         return CW'(T_DPREP - 1);
      ST_DZERO:         return CW'(T_DZERO - 1);
      ST_DTRAIL:        return CW'(T_DTRAIL - 1);
      ST_CPOST:         return CW'(T_CPOST - 1);
      ST_CTRAIL:        return CW'(T_CTRAIL - 1);
      ST_EXIT:          return CW'(T_EXIT - 1);
      ST_INIT:          return CW'(T_INIT - 1);
      ST_WAKE:          return CW'(T_WAKE - 1);
      default:          return '0;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      ST_INIT:   nxt = ST_IDLE;
      ST_IDLE:   nxt = burst_req ? ST_CLPX : (ulps_req ? ST_ULPS : ST_IDLE);
      ST_CLPX:   nxt = ST_CPREP;
      ST_CPREP:  nxt = ST_CZERO;
      ST_CZERO:  nxt = ST_CPRE;
      ST_CPRE:   nxt = ST_DLPX;
      ST_DLPX:   nxt = ST_DPREP;
      ST_DPREP:  nxt = ST_DZERO;
      ST_DZERO:  nxt = ST_DSYNC;
      ST_DSYNC:  nxt = ST_DPAY;
      ST_DPAY:   nxt = (pay_valid && pay_last) ? ST_DTRAIL : ST_DPAY;
      ST_DTRAIL: nxt = ST_CPOST;
      ST_CPOST:  nxt = ST_CTRAIL;
      ST_CTRAIL: nxt = ST_EXIT;
      ST_EXIT:   nxt = ST_IDLE;
      ST_ULPS:   nxt = ulps_req ? ST_ULPS : ST_WAKE;
      ST_WAKE:   nxt = ST_IDLE;
      default:   nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_INIT;
      cnt       <= CW'(T_INIT - 1);
      trail_bit <= 1'b0;
    end else begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        st  <= nxt;
        cnt <= span(nxt);
      end
      if (st == ST_DPAY && pay_valid && pay_last)
        trail_bit <= ~pay_data[7];
    end
  end

  logic clk_hs, dat_hs;
  assign clk_hs = st inside {ST_CZERO, ST_CPRE, ST_DLPX, ST_DPREP, ST_DZERO, ST_DSYNC,
                             ST_DPAY, ST_DTRAIL, ST_CPOST, ST_CTRAIL};
  assign dat_hs = st inside {ST_DZERO, ST_DSYNC, ST_DPAY, ST_DTRAIL};

  assign clk_lp = (st == ST_WAKE) ? 2'b10 :
                  (st == ST_CLPX) ? 2'b01 :
                  (st == ST_ULPS || st == ST_CPREP || clk_hs) ? 2'b00 : 2'b11;
  assign dat_lp = (st == ST_WAKE) ? 2'b10 :
                  (st == ST_DLPX) ? 2'b01 :
                  (st == ST_ULPS || st == ST_DPREP || dat_hs) ? 2'b00 : 2'b11;

  assign clk_hs_en   = clk_hs;
  assign clk_hs_zero = st == ST_CZERO || st == ST_CTRAIL;
  assign dat_hs_en   = dat_hs;
  assign dat_hs_zero = st == ST_DZERO;
  assign dat_sync    = st == ST_DSYNC;
  assign dat_trail   = st == ST_DTRAIL;
  assign pay_ready   = st == ST_DPAY;
  assign lane_idle   = st == ST_IDLE;

  assign dat_byte = (st == ST_DSYNC)  ? 8'hB8 :
                    (st == ST_DPAY)   ? pay_data :
                    (st == ST_DTRAIL) ? {8{trail_bit}} : 8'h00;

endmodule

// File: rtl/hs_lane_seq_chk.sv
module hs_lane_seq_chk #(
  parameter int CLK_PS = 5000,
  parameter int UI_PS  = 1250
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pay_ready,
  input logic       lane_idle,
  input logic [1:0] clk_lp,
  input logic       clk_hs_en,
  input logic       clk_hs_zero,
  input logic [1:0] dat_lp,
  input logic       dat_hs_en,
  input logic       dat_hs_zero,
  input logic       dat_sync
);

  localparam int POST_MIN = (60000 + 52 * UI_PS + CLK_PS - 1) / CLK_PS;

  logic [15:0] post_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           post_run <= '0;
    else if (dat_hs_en)                   post_run <= '0;
    else if (clk_hs_en && post_run != '1) post_run <= post_run + 1'b1;
  end

  assert_clock_under_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dat_hs_en |-> (clk_hs_en && !clk_hs_zero));

  assert_clock_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(clk_hs_zero) && $past(clk_hs_en)) |-> (int'(post_run) >= POST_MIN));

  assert_sync_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_sync |=> (!dat_sync && pay_ready));

  assert_ready_after_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_ready) |-> $past(dat_sync));

  assert_hs_from_lp00_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_hs_en) |-> ($past(dat_lp) == 2'b00 && dat_hs_zero));

  assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lp == 2'b01 && $past(clk_lp) != 2'b01) |-> $past(lane_idle));

endmodule

bind hs_lane_seq hs_lane_seq_chk #(.CLK_PS(CLK_PS), .UI_PS(UI_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pay_ready(pay_ready), .lane_idle(lane_idle),
  .clk_lp(clk_lp), .clk_hs_en(clk_hs_en), .clk_hs_zero(clk_hs_zero),
  .dat_lp(dat_lp), .dat_hs_en(dat_hs_en), .dat_hs_zero(dat_hs_zero), .dat_sync(dat_sync)
);

// File: tb/test_hs_lane_seq.sv
module test_hs_lane_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPS = 5000;
  localparam int UPS = 1250;
  localparam int INI = 2000;
  localparam int WAK = 1500;

  localparam int E_INIT = (INI * 1000 + CPS - 1) / CPS;
  localparam int E_WAKE = (WAK * 1000 + CPS - 1) / CPS;

  // rows: {idle,ready,clk_lp,chs,cz,dat_lp,dhs,dz,sync,trail}; len 0 = payload
  localparam logic [11:0] ROW_SIG [13] = '{
    12'b0_0_01_0_0_11_0_0_0_0,  // R2 clock LP-01
    12'b0_0_00_0_0_11_0_0_0_0,  // R2 clock prepare
    12'b0_0_00_1_1_11_0_0_0_0,  // R2 clock zero
    12'b0_0_00_1_0_11_0_0_0_0,  // R3 clock pre
    12'b0_0_00_1_0_01_0_0_0_0,  // R4 data LP-01
    12'b0_0_00_1_0_00_0_0_0_0,  // R4 data prepare
    12'b0_0_00_1_0_00_1_1_0_0,  // R4 data zero
    12'b0_0_00_1_0_00_1_0_1_0,  // R5 sync
    12'b0_1_00_1_0_00_1_0_0_0,  // R6 payload
    12'b0_0_00_1_0_00_1_0_0_1,  // R7 data trail
    12'b0_0_00_1_0_11_0_0_0_0,  // R8 clock post
    12'b0_0_00_1_1_11_0_0_0_0,  // R9 clock trail
    12'b0_0_11_0_0_11_0_0_0_0   // R10 exit LP-11
  };
  localparam int ROW_LEN [13] = '{
    (50000 + CPS - 1) / CPS,
    (66500 + CPS - 1) / CPS,
    (300000 + CPS - 1) / CPS - (66500 + CPS - 1) / CPS,
    (8 * UPS + CPS - 1) / CPS,
    (50000 + CPS - 1) / CPS,
    ((125000 + 10 * UPS) / 2 + CPS - 1) / CPS,
    (145000 + 10 * UPS + CPS - 1) / CPS - ((125000 + 10 * UPS) / 2 + CPS - 1) / CPS,
    1,
    0,
    (60000 + 4 * UPS + CPS - 1) / CPS,
    (60000 + 52 * UPS + CPS - 1) / CPS,
    (60000 + CPS - 1) / CPS,
    (100000 + CPS - 1) / CPS
  };
  localparam int ROW_REQ [13] = '{2, 2, 2, 3, 4, 4, 4, 5, 6, 7, 8, 9, 10};
  localparam logic [11:0] SIG_IDLE = 12'b1_0_11_0_0_11_0_0_0_0;
  localparam logic [11:0] SIG_RST  = 12'b0_0_11_0_0_11_0_0_0_0;

  logic clk = 0, rst_n = 0, burst_req = 0, ulps_req = 0;
  logic pay_valid = 0, pay_last = 0;
  logic [7:0] pay_data = 0;
  logic pay_ready, lane_idle, clk_hs_en, clk_hs_zero, dat_hs_en, dat_hs_zero, dat_sync, dat_trail;
  logic [1:0] clk_lp, dat_lp;
  logic [7:0] dat_byte;

  int total = 0, bad = 0;
  int beats_n = 1, stall_left = 0, beat = 0;
  logic [7:0] last_val = 0;
  int meas [13];

  always #(CLK_PERIOD / 2) clk = ~clk;

  hs_lane_seq #(.CLK_PS(CPS), .UI_PS(UPS), .INIT_NS(INI), .WAKE_NS(WAK)) i_hs_lane_seq (
    .clk(clk), .rst_n(rst_n), .burst_req(burst_req), .ulps_req(ulps_req),
    .pay_valid(pay_valid), .pay_last(pay_last), .pay_data(pay_data),
    .pay_ready(pay_ready), .lane_idle(lane_idle), .clk_lp(clk_lp),
    .clk_hs_en(clk_hs_en), .clk_hs_zero(clk_hs_zero), .dat_lp(dat_lp),
    .dat_hs_en(dat_hs_en), .dat_hs_zero(dat_hs_zero), .dat_sync(dat_sync),
    .dat_trail(dat_trail), .dat_byte(dat_byte));

  function automatic logic [11:0] sig();
    return {lane_idle, pay_ready, clk_lp, clk_hs_en, clk_hs_zero, dat_lp,
            dat_hs_en, dat_hs_zero, dat_sync, dat_trail};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit ok, input int act, input int lim);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d limit=%0d", req, act, lim);
    end
  endtask

  always @(negedge clk) begin
    if (pay_ready) begin
      if (stall_left > 0) begin
        pay_valid = 0; pay_last = 0; stall_left--;
      end else begin
        pay_valid = 1;
        pay_last  = (beat == beats_n - 1);
        pay_data  = pay_last ? last_val : 8'(8'h11 + beat);
        beat++;
      end
    end else begin
      pay_valid = 0; pay_last = 0; beat = 0;
    end
  end

  task automatic run_burst(input int nb, input int stall, input logic [7:0] lastb, input bit hold_req);
    int n;
    beats_n = nb; stall_left = stall; last_val = lastb;
    burst_req = 1;
    @(negedge clk);
    if (!hold_req) burst_req = 0;
    for (int i = 0; i < 13; i++) begin
      int exp_len;
      exp_len = (ROW_LEN[i] == 0) ? nb + stall : ROW_LEN[i];
      check($sformatf("R%0d row%0d signature", ROW_REQ[i], i), int'(sig()), int'(ROW_SIG[i]));
      if (i == 7) check("R5 sync byte", int'(dat_byte), 8'hB8);
      if (i == 9) check("R7 trail byte", int'(dat_byte), {8{~lastb[7]}});
      if (i == 8) burst_req = 0;
      n = 0;
      while (sig() == ROW_SIG[i] && n < 5000) begin
        n++;
        @(negedge clk);
      end
      meas[i] = n;
      check($sformatf("R%0d row%0d length", ROW_REQ[i], i), n, exp_len);
    end
    check("R10 idle after exit", int'(sig()), int'(SIG_IDLE));
  endtask

  task automatic check_bounds();
    check_true("R2 clock prepare min", meas[1] * CPS >= 38000, meas[1] * CPS, 38000);
    check_true("R2 clock prepare max", meas[1] * CPS <= 95000, meas[1] * CPS, 95000);
    check_true("R2 clock prepare+zero", (meas[1] + meas[2]) * CPS >= 300000, (meas[1] + meas[2]) * CPS, 300000);
    check_true("R3 clock pre", meas[3] * CPS >= 8 * UPS, meas[3] * CPS, 8 * UPS);
    check_true("R4 data LP-01", meas[4] * CPS >= 50000, meas[4] * CPS, 50000);
    check_true("R4 data prepare min", meas[5] * CPS >= 40000 + 4 * UPS, meas[5] * CPS, 40000 + 4 * UPS);
    check_true("R4 data prepare max", meas[5] * CPS <= 85000 + 6 * UPS, meas[5] * CPS, 85000 + 6 * UPS);
    check_true("R4 data prepare+zero", (meas[5] + meas[6]) * CPS >= 145000 + 10 * UPS, (meas[5] + meas[6]) * CPS, 145000 + 10 * UPS);
    check_true("R7 trail min", meas[9] * CPS >= 60000 + 4 * UPS, meas[9] * CPS, 60000 + 4 * UPS);
    check_true("R7 trail max", meas[9] * CPS <= 105000 + 12 * UPS, meas[9] * CPS, 105000 + 12 * UPS);
    check_true("R8 clock post", meas[10] * CPS >= 60000 + 52 * UPS, meas[10] * CPS, 60000 + 52 * UPS);
    check_true("R9 clock trail", meas[11] * CPS >= 60000, meas[11] * CPS, 60000);
    check_true("R10 exit LP-11", meas[12] * CPS >= 100000, meas[12] * CPS, 100000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset lanes LP-11", int'(sig()), int'(SIG_RST));
    rst_n = 1;
    n = 0;
    while (!lane_idle && n < 100000) begin
      if (sig() != SIG_RST) check("R1 init holds LP-11", int'(sig()), int'(SIG_RST));
      n++;
      @(negedge clk);
    end
    check("R1 init length", n, E_INIT);
    repeat (3) @(negedge clk);

    run_burst(4, 0, 8'h85, 0);
    check_bounds();
    repeat (2) @(negedge clk);
    run_burst(1, 3, 8'h42, 0);     // R6 stall lengthens payload
    repeat (2) @(negedge clk);
    run_burst(6, 2, 8'hF0, 1);     // R11 request held into the burst
    n = 0;
    repeat (30) begin
      if (sig() == SIG_IDLE) n++;
      @(negedge clk);
    end
    check("R11 no burst queued from busy request", n, 30);

    ulps_req = 1;
    @(negedge clk);
    check("R12 ULPS clock lane LP-00", int'(clk_lp), 0);
    check("R12 ULPS data lane LP-00", int'(dat_lp), 0);
    burst_req = 1;
    repeat (3) @(negedge clk);
    burst_req = 0;
    check("R11 request ignored in ULPS", int'({clk_lp, dat_lp, clk_hs_en, lane_idle}), 0);
    ulps_req = 0;
    @(negedge clk);
    n = 0;
    while (clk_lp == 2'b10 && dat_lp == 2'b10 && n < 100000) begin
      n++;
      @(negedge clk);
    end
    check("R12 wake length", n, E_WAKE);
    check("R12 idle after wake", int'(sig()), int'(SIG_IDLE));

    run_burst(2, 0, 8'h7F, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule